// File: doc/BRIEF.md
# Host/Core Mailbox Unit

This block carries 32-bit messages between a host bus agent and an accelerator core. Two mailboxes run from core to host, each holding a single word: a plain outbound mailbox and an interrupt mailbox. A third mailbox runs from host to core and queues up to four words. The host sees all three through one packed status word. Each host operation returns a success flag in the same cycle it is issued. The core sees per-mailbox channel counts and a success flag on each of its channel accesses.

Host operations that complete raise core events. An event sets its bit in a pending-event register, and under a rule that depends on the mask it also sets a one-bit event count. When a host operation finds nothing to do, it arms an interrupt enable, so that the host is woken when the condition changes. Core activity sets matching interrupt status bits. The interrupt line is the OR of the status bits that are enabled.

Top module: `mbx_unit`

## Requirements
- R1: After reset the status word `h_status` reads 0x000400. Its layout is: bits [7:0] = outbound mailbox entries (0 or 1), bits [15:8] = free inbound slots, bits [23:16] = interrupt mailbox entries (0 or 1). Also after reset: `c_cnt_out`=1, `c_cnt_int`=1, `c_cnt_in`=0, and `ev_pend`, `ev_cnt`, `irq_en`, `irq_stat` are all 0.
- R2: A host read (`h_rd_out`) of a non-empty outbound mailbox does all of the following: it returns the word on `h_out_data` with `h_out_ok`=1, it clears status bits [7:0], it sets `c_cnt_out` to 1, and it raises event bit 0. A host read of an empty outbound mailbox gives `h_out_ok`=0.
- R3: A host read (`h_rd_int`) of a non-empty interrupt mailbox does all of the following: it returns the word with `h_int_ok`=1, it clears status bits [23:16], it sets `c_cnt_int` to 1, and it raises event bit 1. A host read of an empty interrupt mailbox gives `h_int_ok`=0 and sets `irq_en[0]`, the mailbox-available enable.
- R4: A host write (`h_wr_in`) while free slots are non-zero does all of the following: it gives `h_wr_ok`=1, it stores the word at the index equal to `c_cnt_in`, it increments `c_cnt_in`, it sets status bits [15:8] to 4 minus the new count, and it raises event bit 2.
- R5: A host write while no slot is free gives `h_wr_ok`=0. It leaves the queue and its count unchanged, and it sets `irq_en[1]`, the space-available enable.
- R6: A core read (`c_rd_in`) of a non-empty inbound mailbox does all of the following: it returns the oldest word with `c_in_ok`=1, it decrements `c_cnt_in`, and it adds one to the free slots. A core read of an empty inbound mailbox gives `c_in_ok`=0.
- R7: A raised event always sets its bit in `ev_pend`. It sets `ev_cnt` to 1 only when all three of these hold: `ev_cnt` was 0, the bit was not already pending, and its `ev_mask` bit is 1. A non-zero `ev_ack` clears the pending bits it names and clears `ev_cnt`. The acknowledge is applied before the events of the same cycle.
- R8: A core write to the outbound mailbox or to the interrupt mailbox is accepted (`c_out_ok`/`c_int_ok`=1) only when its channel count is 1, and the count then drops to 0. A write to a full mailbox is refused and leaves the stored word unchanged.
- R9: When the core and the host access the same mailbox in one cycle, the core access is applied first. A host write to a full inbound mailbox therefore succeeds if the core reads in the same cycle. A host read of an empty outbound mailbox returns the word the core writes in that cycle.
- R10: The free-slot byte always equals 4 minus `c_cnt_in`. The sticky flag `err` goes high if the two ever disagree.
- R11: An accepted core write to the interrupt mailbox sets `irq_stat[0]`. A successful core inbound read sets `irq_stat[1]`. `irq` = OR of (`irq_stat` AND `irq_en`). `h_irq_ack` clears the named bits of both `irq_stat` and `irq_en`, and is applied before the sets of the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_rd_out | input | 1 | Host reads outbound mailbox |
| h_rd_int | input | 1 | Host reads interrupt mailbox |
| h_wr_in | input | 1 | Host writes inbound mailbox |
| h_wdata | input | 32 | Host write word |
| h_irq_ack | input | 2 | Clear interrupt status and enable bits |
| h_out_ok | output | 1 | Outbound read succeeded |
| h_out_data | output | 32 | Outbound read word |
| h_int_ok | output | 1 | Interrupt mailbox read succeeded |
| h_int_data | output | 32 | Interrupt mailbox read word |
| h_wr_ok | output | 1 | Inbound write accepted |
| h_status | output | 24 | Packed mailbox status |
| irq_en | output | 2 | Interrupt enables: [0] available, [1] space |
| irq_stat | output | 2 | Interrupt status bits |
| irq | output | 1 | Interrupt request |
| c_wr_out | input | 1 | Core writes outbound mailbox |
| c_out_wdata | input | 32 | Core outbound word |
| c_wr_int | input | 1 | Core writes interrupt mailbox |
| c_int_wdata | input | 32 | Core interrupt mailbox word |
| c_rd_in | input | 1 | Core reads inbound mailbox |
| ev_mask | input | 3 | Event mask |
| ev_ack | input | 3 | Event acknowledge |
| c_out_ok | output | 1 | Core outbound write accepted |
| c_int_ok | output | 1 | Core interrupt write accepted |
| c_in_ok | output | 1 | Core inbound read succeeded |
| c_in_data | output | 32 | Core inbound read word |
| c_cnt_out | output | 1 | Outbound channel count (space) |
| c_cnt_int | output | 1 | Interrupt channel count (space) |
| c_cnt_in | output | 3 | Inbound entries queued |
| ev_pend | output | 3 | Pending events |
| ev_cnt | output | 1 | Event count |
| err | output | 1 | Sticky free-slot mismatch flag |

## Verification
The case that needs care is two parties working on one mailbox in the same cycle. One instance is a core read of the inbound queue that lands together with a host write to a full queue. The other is a core write to the outbound mailbox that lands together with a host read of it while it is empty. The bench drives both sides in one cycle and samples the same-cycle success flags before the clock edge. It then checks three things: that the host write is accepted, that both the popped word and the new word appear in the right places of the FIFO order, and that after the edge the outbound mailbox is empty again with its channel count at 1.

// File: rtl/mbx_pkg.sv
`timescale 1ns/100ps
package mbx_pkg;
    localparam int DATA_W   = 32;
    localparam int IN_DEPTH = 4;
    localparam int EV_W     = 3;
    localparam int IRQ_W    = 2;

    // event bit positions
    localparam int EV_OUT_TAKEN = 0;
    localparam int EV_INT_TAKEN = 1;
    localparam int EV_IN_FILLED = 2;

    // interrupt bit positions
    localparam int IRQ_AVAIL = 0;
    localparam int IRQ_SPACE = 1;

    typedef struct packed {
        logic [7:0] int_cnt;
        logic [7:0] free;
        logic [7:0] out_cnt;
    } status_t;

    function automatic logic [7:0] free_of(input int depth, input int cnt);
        return 8'(depth - cnt);
    endfunction
endpackage

// File: rtl/mbx_slot.sv
`timescale 1ns/100ps
module mbx_slot #(
    parameter int DW = mbx_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [DW-1:0] rdata,
    output logic          full
);
    logic          vld_q;
    logic [DW-1:0] dat_q;
    logic          vld_a;
    logic [DW-1:0] dat_a;

    // core side first, host read sees the result
    always_comb begin
        wr_ok = wr && !vld_q;
        vld_a = vld_q | wr_ok;
        dat_a = wr_ok ? wdata : dat_q;
        rd_ok = rd && vld_a;
        rdata = rd_ok ? dat_a : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_a & ~rd_ok;
            dat_q <= dat_a;
        end
    end

    assign full = vld_q;
endmodule

// File: rtl/mbx_inq.sv
`timescale 1ns/100ps
module mbx_inq #(
    parameter int DW    = mbx_pkg::DATA_W,
    parameter int DEPTH = mbx_pkg::IN_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    output logic          pop_ok,
    output logic [DW-1:0] pop_data,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    output logic          push_ok,
    output logic [CW-1:0] count,
    output logic [7:0]    free,
    output logic          err
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_a [DEPTH];
    logic [DW-1:0] mem_n [DEPTH];
    logic [CW-1:0] cnt_q, cnt_a, cnt_n;
    logic [7:0]    free_q, free_a, free_n;
    logic          err_q;

    always_comb begin
        pop_ok   = pop && (cnt_q != '0);
        pop_data = pop_ok ? mem_q[0] : '0;
        cnt_a    = cnt_q - CW'(pop_ok);
        free_a   = free_q + 8'(pop_ok);
        push_ok  = push && (free_a != 8'd0);
        cnt_n    = cnt_a + CW'(push_ok);
        free_n   = push_ok ? mbx_pkg::free_of(DEPTH, int'(cnt_n)) : free_a;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i < DEPTH - 1) begin : g_shift
            assign mem_a[i] = pop_ok ? mem_q[i+1] : mem_q[i];
        end else begin : g_tail
            assign mem_a[i] = pop_ok ? '0 : mem_q[i];
        end
        assign mem_n[i] = (push_ok && cnt_a == CW'(i)) ? push_data : mem_a[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            cnt_q  <= '0;
            free_q <= 8'(DEPTH);
            err_q  <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
            cnt_q  <= cnt_n;
            free_q <= free_n;
            err_q  <= err_q | (free_q != mbx_pkg::free_of(DEPTH, int'(cnt_q)));
        end
    end

    assign count = cnt_q;
    assign free  = free_q;
    assign err   = err_q;
endmodule

// File: rtl/mbx_evt.sv
`timescale 1ns/100ps
module mbx_evt #(
    parameter int EW = mbx_pkg::EV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [EW-1:0] raise,
    input  logic [EW-1:0] mask,
    input  logic [EW-1:0] ack,
    output logic [EW-1:0] pend,
    output logic          cnt
);
    logic [EW-1:0] pend_q, pend_a;
    logic          cnt_q, cnt_a, fresh;

    always_comb begin
        pend_a = pend_q & ~ack;
        cnt_a  = (ack != '0) ? 1'b0 : cnt_q;
        fresh  = |(raise & ~pend_a & mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cnt_q  <= 1'b0;
        end else begin
            pend_q <= pend_a | raise;
            cnt_q  <= cnt_a | (!cnt_a && fresh);
        end
    end

    assign pend = pend_q;
    assign cnt  = cnt_q;
endmodule

// File: rtl/mbx_unit.sv
`timescale 1ns/100ps
module mbx_unit #(
    parameter int DW    = mbx_pkg::DATA_W,
    parameter int DEPTH = mbx_pkg::IN_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int EW   = mbx_pkg::EV_W,
    localparam int IW   = mbx_pkg::IRQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          h_rd_out,
    input  logic          h_rd_int,
    input  logic          h_wr_in,
    input  logic [DW-1:0] h_wdata,
    input  logic [IW-1:0] h_irq_ack,
    output logic          h_out_ok,
    output logic [DW-1:0] h_out_data,
    output logic          h_int_ok,
    output logic [DW-1:0] h_int_data,
    output logic          h_wr_ok,
    output logic [23:0]   h_status,
    output logic [IW-1:0] irq_en,
    output logic [IW-1:0] irq_stat,
    output logic          irq,
    input  logic          c_wr_out,
    input  logic [DW-1:0] c_out_wdata,
    input  logic          c_wr_int,
    input  logic [DW-1:0] c_int_wdata,
    input  logic          c_rd_in,
    input  logic [EW-1:0] ev_mask,
    input  logic [EW-1:0] ev_ack,
    output logic          c_out_ok,
    output logic          c_int_ok,
    output logic          c_in_ok,
    output logic [DW-1:0] c_in_data,
    output logic          c_cnt_out,
    output logic          c_cnt_int,
    output logic [CW-1:0] c_cnt_in,
    output logic [EW-1:0] ev_pend,
    output logic          ev_cnt,
    output logic          err
);
    import mbx_pkg::*;

    logic          out_full, int_full;
    logic [7:0]    free_slots;
    logic [EW-1:0] raise;
    logic [IW-1:0] en_q, stat_q, en_set, stat_set;
    status_t       stat_word;

    mbx_slot #(.DW(DW)) out_i (
        .clk(clk), .rst(rst),
        .wr(c_wr_out), .wdata(c_out_wdata), .rd(h_rd_out),
        .wr_ok(c_out_ok), .rd_ok(h_out_ok), .rdata(h_out_data),
        .full(out_full)
    );

    mbx_slot #(.DW(DW)) int_i (
        .clk(clk), .rst(rst),
        .wr(c_wr_int), .wdata(c_int_wdata), .rd(h_rd_int),
        .wr_ok(c_int_ok), .rd_ok(h_int_ok), .rdata(h_int_data),
        .full(int_full)
    );

    mbx_inq #(.DW(DW), .DEPTH(DEPTH)) inq_i (
        .clk(clk), .rst(rst),
        .pop(c_rd_in), .pop_ok(c_in_ok), .pop_data(c_in_data),
        .push(h_wr_in), .push_data(h_wdata), .push_ok(h_wr_ok),
        .count(c_cnt_in), .free(free_slots), .err(err)
    );

    always_comb begin
        raise               = '0;
        raise[EV_OUT_TAKEN] = h_out_ok;
        raise[EV_INT_TAKEN] = h_int_ok;
        raise[EV_IN_FILLED] = h_wr_ok;
    end

    mbx_evt #(.EW(EW)) evt_i (
        .clk(clk), .rst(rst),
        .raise(raise), .mask(ev_mask), .ack(ev_ack),
        .pend(ev_pend), .cnt(ev_cnt)
    );

    // interrupt enables armed by host operations that found nothing to do
    always_comb begin
        en_set              = '0;
        en_set[IRQ_AVAIL]   = h_rd_int && !h_int_ok;
        en_set[IRQ_SPACE]   = h_wr_in && !h_wr_ok;
        stat_set            = '0;
        stat_set[IRQ_AVAIL] = c_int_ok;
        stat_set[IRQ_SPACE] = c_in_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            stat_q <= '0;
        end else begin
            en_q   <= (en_q & ~h_irq_ack) | en_set;
            stat_q <= (stat_q & ~h_irq_ack) | stat_set;
        end
    end

    always_comb begin
        stat_word.out_cnt = {7'd0, out_full};
        stat_word.free    = free_slots;
        stat_word.int_cnt = {7'd0, int_full};
    end

    assign h_status  = stat_word;
    assign irq_en    = en_q;
    assign irq_stat  = stat_q;
    assign irq       = |(stat_q & en_q);
    assign c_cnt_out = ~out_full;
    assign c_cnt_int = ~int_full;
endmodule

// File: rtl/mbx_unit_chk.sv
`timescale 1ns/100ps
module mbx_unit_chk #(
    parameter int DEPTH = mbx_pkg::IN_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          h_rd_out,
    input logic          h_out_ok,
    input logic          h_rd_int,
    input logic          h_int_ok,
    input logic          h_wr_in,
    input logic          h_wr_ok,
    input logic [23:0]   h_status,
    input logic [1:0]    irq_en,
    input logic [1:0]    irq_stat,
    input logic          c_wr_int,
    input logic          c_int_ok,
    input logic          c_rd_in,
    input logic          c_in_ok,
    input logic          c_cnt_out,
    input logic [CW-1:0] c_cnt_in,
    input logic [2:0]    ev_pend,
    input logic          ev_cnt,
    input logic          err
);
    assert_free_matches_R1: assert property (@(posedge clk) disable iff (rst)
        h_status[15:8] == 8'(DEPTH) - 8'(c_cnt_in));

    assert_out_drained_R2: assert property (@(posedge clk) disable iff (rst)
        (h_rd_out && h_out_ok) |=> (h_status[7:0] == 8'd0 && c_cnt_out));

    assert_int_empty_arms_R3: assert property (@(posedge clk) disable iff (rst)
        (h_rd_int && !h_int_ok) |=> irq_en[0]);

    assert_full_write_arms_R5: assert property (@(posedge clk) disable iff (rst)
        (h_wr_in && !h_wr_ok) |=> irq_en[1]);

    assert_pop_decrements_R6: assert property (@(posedge clk) disable iff (rst)
        (c_rd_in && c_in_ok && !h_wr_in) |=> (c_cnt_in == $past(c_cnt_in) - CW'(1)));

    assert_count_needs_pending_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ev_cnt) |-> (ev_pend != 3'd0));

    assert_no_mismatch_R10: assert property (@(posedge clk) disable iff (rst)
        !err);

    assert_int_write_flags_R11: assert property (@(posedge clk) disable iff (rst)
        (c_wr_int && c_int_ok) |=> irq_stat[0]);
endmodule

bind mbx_unit mbx_unit_chk #(.DEPTH(DEPTH)) chk_i (
    .clk, .rst, .h_rd_out, .h_out_ok, .h_rd_int, .h_int_ok, .h_wr_in, .h_wr_ok,
    .h_status, .irq_en, .irq_stat, .c_wr_int, .c_int_ok, .c_rd_in, .c_in_ok,
    .c_cnt_out, .c_cnt_in, .ev_pend, .ev_cnt, .err
);

// File: tb/mbx_unit_tb_top.sv
`timescale 1ns/100ps
module mbx_unit_tb_top;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;
    logic h_rd_out, h_rd_int, h_wr_in;
    logic [DW-1:0] h_wdata;
    logic [1:0] h_irq_ack;
    logic h_out_ok, h_int_ok, h_wr_ok, irq;
    logic [DW-1:0] h_out_data, h_int_data;
    logic [23:0] h_status;
    logic [1:0] irq_en, irq_stat;
    logic c_wr_out, c_wr_int, c_rd_in;
    logic [DW-1:0] c_out_wdata, c_int_wdata;
    logic [2:0] ev_mask, ev_ack;
    logic c_out_ok, c_int_ok, c_in_ok;
    logic [DW-1:0] c_in_data;
    logic c_cnt_out, c_cnt_int;
    logic [CW-1:0] c_cnt_in;
    logic [2:0] ev_pend;
    logic ev_cnt, err;

    mbx_unit dut_i (.*);

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] out_q[$];
    logic [DW-1:0] in_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // monitor: pops expected words as the design delivers them
    always @(negedge clk) begin
        if (!rst && h_rd_out && h_out_ok) begin
            if (out_q.size() == 0) chk("R2 unexpected outbound word", h_out_data, 32'hx);
            else chk("R2 outbound word", h_out_data, out_q.pop_front());
        end
        if (!rst && c_rd_in && c_in_ok) begin
            if (in_q.size() == 0) chk("R6 unexpected inbound word", c_in_data, 32'hx);
            else chk("R6 inbound FIFO order", c_in_data, in_q.pop_front());
        end
    end

    task automatic core_out_write(input logic [31:0] d, input logic exp_ok);
        c_wr_out = 1'b1; c_out_wdata = d;
        #1;
        chk("R8 core outbound accept", 32'(c_out_ok), 32'(exp_ok));
        if (exp_ok) out_q.push_back(d);
        tick();
        c_wr_out = 1'b0;
    endtask

    task automatic host_rd_out(input logic exp_ok);
        h_rd_out = 1'b1;
        #1;
        chk("R2 host outbound ok", 32'(h_out_ok), 32'(exp_ok));
        tick();
        h_rd_out = 1'b0;
    endtask

    task automatic host_write(input logic [31:0] d, input logic exp_ok);
        h_wr_in = 1'b1; h_wdata = d;
        #1;
        chk(exp_ok ? "R4 host write accept" : "R5 host write refused", 32'(h_wr_ok), 32'(exp_ok));
        if (exp_ok) in_q.push_back(d);
        tick();
        h_wr_in = 1'b0;
    endtask

    task automatic core_read(input logic exp_ok);
        c_rd_in = 1'b1;
        #1;
        chk("R6 core read ok", 32'(c_in_ok), 32'(exp_ok));
        tick();
        c_rd_in = 1'b0;
    endtask

    task automatic ack_events();
        ev_ack = 3'b111;
        tick();
        ev_ack = 3'b000;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        h_rd_out = 0; h_rd_int = 0; h_wr_in = 0; h_wdata = '0; h_irq_ack = '0;
        c_wr_out = 0; c_wr_int = 0; c_rd_in = 0; c_out_wdata = '0; c_int_wdata = '0;
        ev_mask = 3'b111; ev_ack = 3'b000;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        chk("R1 reset status", 32'(h_status), 32'h000400);
        chk("R1 reset cnt_out", 32'(c_cnt_out), 1);
        chk("R1 reset cnt_int", 32'(c_cnt_int), 1);
        chk("R1 reset cnt_in", 32'(c_cnt_in), 0);
        chk("R1 reset events", 32'({ev_pend, ev_cnt}), 0);
        chk("R1 reset irq", 32'({irq_en, irq_stat}), 0);

        // R2 empty read, R8 accept/refuse
        host_rd_out(1'b0);
        core_out_write(32'hA5A50001, 1'b1);
        chk("R1 outbound byte", 32'(h_status[7:0]), 1);
        chk("R8 cnt_out after write", 32'(c_cnt_out), 0);
        core_out_write(32'h0BAD0BAD, 1'b0);
        host_rd_out(1'b1);
        chk("R2 byte0 cleared", 32'(h_status[7:0]), 0);
        chk("R2 cnt_out set", 32'(c_cnt_out), 1);
        chk("R2 event bit0", 32'(ev_pend), 32'b001);
        chk("R7 count set", 32'(ev_cnt), 1);

        // R7 masked and already-pending cases
        ack_events();
        chk("R7 ack clears", 32'({ev_pend, ev_cnt}), 0);
        ev_mask = 3'b000;
        core_out_write(32'h11, 1'b1);
        host_rd_out(1'b1);
        chk("R7 masked pend", 32'(ev_pend), 32'b001);
        chk("R7 masked count", 32'(ev_cnt), 0);
        ev_mask = 3'b111;
        core_out_write(32'h22, 1'b1);
        host_rd_out(1'b1);
        chk("R7 already pending count", 32'(ev_cnt), 0);
        ack_events();

        // R3 interrupt mailbox, R11 interrupt status
        h_rd_int = 1'b1;
        #1;
        chk("R3 empty int read", 32'(h_int_ok), 0);
        tick();
        h_rd_int = 1'b0;
        chk("R3 avail enable armed", 32'(irq_en), 32'b01);
        chk("R11 no irq yet", 32'(irq), 0);
        c_wr_int = 1'b1; c_int_wdata = 32'h1234;
        #1;
        chk("R8 core int accept", 32'(c_int_ok), 1);
        tick();
        c_wr_int = 1'b0;
        chk("R1 int byte", 32'(h_status[23:16]), 1);
        chk("R8 cnt_int after write", 32'(c_cnt_int), 0);
        chk("R11 irq_stat bit0", 32'(irq_stat), 32'b01);
        chk("R11 irq raised", 32'(irq), 1);
        h_rd_int = 1'b1;
        #1;
        chk("R3 int read ok", 32'(h_int_ok), 1);
        chk("R3 int read data", h_int_data, 32'h1234);
        tick();
        h_rd_int = 1'b0;
        chk("R3 byte2 cleared", 32'(h_status[23:16]), 0);
        chk("R3 cnt_int set", 32'(c_cnt_int), 1);
        chk("R3 event bit1", 32'(ev_pend[1]), 1);
        h_irq_ack = 2'b01; ev_ack = 3'b111;
        tick();
        h_irq_ack = 2'b00; ev_ack = 3'b000;
        chk("R11 ack clears", 32'({irq_en, irq_stat, irq}), 0);

        // R4 fill inbound, R5 refuse when full
        for (int i = 0; i < DEPTH; i++) begin
            host_write(32'hD0 + 32'(i), 1'b1);
            chk("R4 cnt_in", 32'(c_cnt_in), 32'(i + 1));
            chk("R4 free byte", 32'(h_status[15:8]), 32'(DEPTH - 1 - i));
        end
        chk("R4 event bit2", 32'(ev_pend[2]), 1);
        host_write(32'hDEAD, 1'b0);
        chk("R5 space enable armed", 32'(irq_en), 32'b10);
        chk("R5 count unchanged", 32'(c_cnt_in), 32'(DEPTH));
        chk("R5 free zero", 32'(h_status[15:8]), 0);

        // R6 core reads
        core_read(1'b1);
        chk("R6 cnt after pop", 32'(c_cnt_in), 3);
        chk("R6 free after pop", 32'(h_status[15:8]), 1);
        chk("R11 irq_stat bit1", 32'(irq_stat), 32'b10);
        chk("R11 irq space", 32'(irq), 1);
        core_read(1'b1);

        // R9 simultaneous core read and host write on a full queue
        host_write(32'hE0, 1'b1);
        host_write(32'hE1, 1'b1);
        chk("R9 full before", 32'(c_cnt_in), 32'(DEPTH));
        c_rd_in = 1'b1; h_wr_in = 1'b1; h_wdata = 32'hE2;
        #1;
        chk("R9 host write sees freed slot", 32'(h_wr_ok), 1);
        chk("R9 core read ok", 32'(c_in_ok), 1);
        in_q.push_back(32'hE2);
        tick();
        c_rd_in = 1'b0; h_wr_in = 1'b0;
        chk("R9 count stays full", 32'(c_cnt_in), 32'(DEPTH));
        chk("R9 free stays zero", 32'(h_status[15:8]), 0);
        for (int i = 0; i < DEPTH; i++) core_read(1'b1);
        core_read(1'b0);
        chk("R6 empty status", 32'(h_status[15:8]), 32'(DEPTH));

        // R9 simultaneous core write and host read of empty outbound
        c_wr_out = 1'b1; c_out_wdata = 32'h77; h_rd_out = 1'b1;
        #1;
        chk("R9 host read gets same-cycle word", 32'(h_out_ok), 1);
        chk("R9 core write accepted", 32'(c_out_ok), 1);
        out_q.push_back(32'h77);
        tick();
        c_wr_out = 1'b0; h_rd_out = 1'b0;
        chk("R9 outbound empty after", 32'(h_status[7:0]), 0);
        chk("R9 cnt_out after", 32'(c_cnt_out), 1);

        chk("R10 no mismatch", 32'(err), 0);
        chk("R2 outbound queue drained", 32'(out_q.size()), 0);
        chk("R6 inbound queue drained", 32'(in_q.size()), 0);

        summary();
        $finish;
    end
endmodule